// File: doc/BRIEF.md
# Receive Descriptor Chain Engine

This block moves received frames from a byte stream into memory buffers. The buffers are described by a linked chain of four-word receive descriptors. For each frame it first checks the receive enable and the accept-all-unicast switch. It then fetches the current descriptor and checks that the engine owns it. It reads the buffer pointer and the link to the next descriptor, and stores the frame one byte per cycle. Last, it writes back a status word that holds the length and the result flags and hands ownership back to the CPU.

After a completed frame the current-descriptor pointer follows the link. Completion, early-notification and receive-interrupt events go to the interrupt block as one-cycle pulses. A descriptor still owned by the CPU raises an unavailable event, and the frame is dropped. The CRC bytes are part of the incoming stream, so they count toward the reported length. Software points the engine at the head of a chain with a load strobe.

Top module: `rxd_engine`

## Requirements
- R1: During and straight after reset, `s_ready`, `mem_req` and every event output are 0, and `cur_desc` is 0.
- R2: The status word is at descriptor offset 0, and its bits 31:30 are the owner field. 2'b10 means the engine owns the descriptor. Any other value pulses `ev_unavail` for one cycle, and the whole frame is then consumed with no memory write and no change of `cur_desc`.
- R3: The descriptor gives the buffer start at offset 4 and the next-descriptor address at offset 12. Byte i of the frame is written to buffer start + i, with `mem_be` = 1 << address[1:0] and the byte repeated on all four lanes of `mem_wdata`.
- R4: The status written back carries in bits 15:0 the count of all stream bytes of the frame, the CRC included. A 64-byte payload with its 4 CRC bytes reports 68.
- R5: The written-back status word has bits 31:30 = 00 and bit 20 = 1. Bit 16 equals `intr_enable`, and bits 31:21, 18:17 are 0.
- R6: With `long_accept` = 1, a frame longer than 1518 bytes is stored in full and bit 19 is set along with bit 20. With `long_accept` = 0, only the first 1518 bytes are written, and the descriptor is neither written back nor advanced, with no event.
- R7: After a completed frame `cur_desc` holds the next-descriptor address read from that descriptor. A `list_load` pulse sets `cur_desc` to `list_addr`.
- R8: Each completed frame pulses `ev_good`, `ev_early` and `ev_intr` together for exactly one cycle, in the cycle of the status write.
- R9: When `rx_enable` = 0 or `ucast_accept` = 0, an arriving frame is consumed with no memory access and no event.
- R10: Once the descriptor is fetched, the engine accepts one stream byte per cycle (`s_ready` = 1) until the byte flagged `s_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception on |
| long_accept | input | 1 | Store frames longer than the normal maximum |
| ucast_accept | input | 1 | Accept all unicast frames without address match |
| intr_enable | input | 1 | Receive interrupt enable, mirrored into status bit 16 |
| list_load | input | 1 | Load `list_addr` into the current-descriptor pointer |
| list_addr | input | 32 | Head of the descriptor chain |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Stream byte taken this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address, word-aligned for word accesses |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| cur_desc | output | 32 | Current receive descriptor address |
| ev_good | output | 1 | Frame received good |
| ev_early | output | 1 | Early notification |
| ev_intr | output | 1 | Receive interrupt event |
| ev_unavail | output | 1 | Descriptor unavailable |

## Verification
The bench targets the owner check. A design that ignored the owner field would overwrite a CPU buffer and advance the pointer. It also targets the length boundary at 1518 bytes. An off-by-one there would store byte 1519, or would complete a frame it should have abandoned. The reported length must include the trailing CRC bytes, so a design that dropped them would report 64 for a 68-byte frame. The ring wrap-around and the filter switches check that the link pointer is followed and that dropped frames leave memory untouched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_STAT, ST_WT_STAT, ST_RD_BUF, ST_WT_BUF,
    ST_RD_NXT, ST_WT_NXT, ST_DATA, ST_WB, ST_DROP
  } rxd_state_e;

  localparam logic [1:0] OWN_ENGINE = 2'b10;
  localparam int BIT_GOOD = 20;
  localparam int BIT_LONG = 19;
  localparam int BIT_INTR = 16;
endpackage

// File: rtl/rxd_gate.sv
module rxd_gate (
  input  logic       rx_enable,
  input  logic       ucast_accept,
  input  logic [1:0] owner,
  output logic       take_frame,
  output logic       owner_ok
);
  import rxd_pkg::*;
  always_comb begin
    take_frame = rx_enable & ucast_accept;
    owner_ok   = (owner == OWN_ENGINE);
  end
endmodule

// File: rtl/rxd_len_ctr.sv
module rxd_len_ctr #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             long_accept,
  output logic [LEN_W-1:0] count,
  output logic             at_max,
  output logic             over,
  output logic             wr_allow
);
  localparam logic [LEN_W-1:0] MAXV = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] SATV = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != SATV));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    count    = cnt_q;
    at_max   = (cnt_q >= MAXV);
    over     = (cnt_q > MAXV);
    wr_allow = long_accept | (cnt_q < MAXV);
  end

  // R4: the byte count only moves on a clear or a counted byte
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/rxd_status_pack.sv
module rxd_status_pack #(
  parameter int LEN_W = 16
) (
  input  logic             good,
  input  logic             too_long,
  input  logic             intr,
  input  logic [LEN_W-1:0] len,
  output logic [31:0]      word
);
  import rxd_pkg::*;
  always_comb begin
    word              = '0;
    word[LEN_W-1:0]   = len;
    word[BIT_GOOD]    = good;
    word[BIT_LONG]    = too_long;
    word[BIT_INTR]    = intr;
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              long_accept,
  input  logic              ucast_accept,
  input  logic              intr_enable,
  input  logic              list_load,
  input  logic [ADDR_W-1:0] list_addr,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] cur_desc,
  output logic              ev_good,
  output logic              ev_early,
  output logic              ev_intr,
  output logic              ev_unavail
);
  import rxd_pkg::*;

  localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_NXT = ADDR_W'(12);

  rxd_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, buf_q, nxt_q;
  logic              cur_en, buf_en, nxt_en;
  logic [ADDR_W-1:0] cur_d;
  logic              take_frame, owner_ok;
  logic              ctr_clr, ctr_inc, at_max, over, wr_allow;
  logic [LEN_W-1:0]  count;
  logic [31:0]       status_word;
  logic [ADDR_W-1:0] byte_addr;
  logic              byte_in;

  rxd_gate u_gate (
    .rx_enable    (rx_enable),
    .ucast_accept (ucast_accept),
    .owner        (mem_rdata[31:30]),
    .take_frame   (take_frame),
    .owner_ok     (owner_ok)
  );

  rxd_len_ctr #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (ctr_clr),
    .inc         (ctr_inc),
    .long_accept (long_accept),
    .count       (count),
    .at_max      (at_max),
    .over        (over),
    .wr_allow    (wr_allow)
  );

  rxd_status_pack #(.LEN_W(LEN_W)) u_pack (
    .good     (1'b1),
    .too_long (over),
    .intr     (intr_enable),
    .len      (count),
    .word     (status_word)
  );

  assign byte_in   = (state_q == ST_DATA) & s_valid;
  assign byte_addr = buf_q + ADDR_W'(count);

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (s_valid) state_d = take_frame ? ST_RD_STAT : ST_DROP;
      ST_RD_STAT: state_d = ST_WT_STAT;
      ST_WT_STAT: state_d = owner_ok ? ST_RD_BUF : ST_DROP;
      ST_RD_BUF:  state_d = ST_WT_BUF;
      ST_WT_BUF:  state_d = ST_RD_NXT;
      ST_RD_NXT:  state_d = ST_WT_NXT;
      ST_WT_NXT:  state_d = ST_DATA;
      ST_DATA:    if (s_valid && s_last)
                    state_d = (at_max && !long_accept) ? ST_IDLE : ST_WB;
      ST_WB:      state_d = ST_IDLE;
      ST_DROP:    if (s_valid && s_last) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // datapath controls
  always_comb begin
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cur_q;
    mem_be     = 4'hF;
    mem_wdata  = status_word;
    s_ready    = (state_q == ST_DATA) | (state_q == ST_DROP);
    ctr_clr    = (state_q == ST_IDLE);
    ctr_inc    = byte_in;
    ev_good    = (state_q == ST_WB);
    ev_unavail = (state_q == ST_WT_STAT) & ~owner_ok;
    buf_en     = (state_q == ST_WT_BUF);
    nxt_en     = (state_q == ST_WT_NXT);
    cur_en     = list_load | (state_q == ST_WB);
    cur_d      = list_load ? list_addr : nxt_q;
    case (state_q)
      ST_RD_STAT: mem_req = 1'b1;
      ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + OFS_BUF; end
      ST_RD_NXT:  begin mem_req = 1'b1; mem_addr = cur_q + OFS_NXT; end
      ST_DATA: begin
        mem_req   = byte_in & wr_allow;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = 4'b0001 << byte_addr[1:0];
        mem_wdata = {4{s_data}};
      end
      ST_WB: begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
    ev_early = ev_good;
    ev_intr  = ev_good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cur_en) cur_q <= cur_d;
      if (buf_en) buf_q <= mem_rdata;
      if (nxt_en) nxt_q <= mem_rdata;
    end
  end

  assign cur_desc = cur_q;

  // R7: completion moves the pointer to the fetched link
  p_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_good |=> ((cur_desc == $past(nxt_q)) || $past(list_load)));
  // R2: write-back releases the descriptor to the CPU
  p_own_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state_q == ST_WB) |-> (mem_wdata[31:30] == 2'b00));
  // R2: an unavailable descriptor leads to draining with no memory access
  p_rdu_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |=> (!mem_req && s_ready));
  // R9: a filtered frame starts no memory traffic
  p_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && s_valid && !(rx_enable && ucast_accept)) |=> !mem_req);
  // R8: completion and unavailability never coincide
  p_evx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_good, ev_unavail}));
endmodule

// File: tb/rxd_engine_tb.sv
module rxd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int NDESC      = 4;
  localparam logic [31:0] DBASE = 32'h100;
  localparam logic [31:0] BBASE = 32'h1000;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_enable, long_accept, ucast_accept, intr_enable, list_load;
  logic [31:0] list_addr;
  logic s_valid, s_last, s_ready;
  logic [7:0] s_data;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
  logic [3:0] mem_be;
  logic ev_good, ev_early, ev_intr, ev_unavail;

  logic [31:0] mem [MEM_WORDS];
  logic [7:0]  frm [2048];
  int checks = 0, errors = 0;
  int n_good = 0, n_early = 0, n_intr = 0, n_unav = 0, n_wr = 0, n_acc = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .long_accept(long_accept),
    .ucast_accept(ucast_accept), .intr_enable(intr_enable), .list_load(list_load),
    .list_addr(list_addr), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_desc(cur_desc), .ev_good(ev_good), .ev_early(ev_early),
    .ev_intr(ev_intr), .ev_unavail(ev_unavail)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(negedge clk) begin
    cyc++;
    if (ev_good) n_good++;
    if (ev_early) n_early++;
    if (ev_intr) n_intr++;
    if (ev_unavail) n_unav++;
    if (mem_req && mem_we) n_wr++;
    if (mem_req) n_acc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] daddr(input int i);
    return DBASE + 32'(16 * i);
  endfunction

  function automatic logic [31:0] exp_status(input int n, input logic ie);
    return {11'b0, 1'b1, (n > 1518), 2'b0, ie, 16'(n)};
  endfunction

  task automatic arm(input int i, input logic [1:0] own);
    mem[daddr(i) >> 2]       = {own, 30'b0};
    mem[(daddr(i) >> 2) + 1] = BBASE + 32'(i * 32'h800);
    mem[(daddr(i) >> 2) + 2] = 32'h0;
    mem[(daddr(i) >> 2) + 3] = daddr((i + 1) % NDESC);
  endtask

  function automatic logic [7:0] rdbyte(input logic [31:0] a);
    return mem[a >> 2][8*a[1:0] +: 8];
  endfunction

  task automatic gen(input int n);
    for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = frm[i]; s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // full check of one completed frame into descriptor i
  task automatic verify(input string req, input int i, input int n, input logic ie,
                        input int g0, input int e0, input int q0);
    int bad = 0;
    logic [31:0] b = BBASE + 32'(i * 32'h800);
    check(req, mem[daddr(i) >> 2], exp_status(n, ie));
    for (int k = 0; k < n; k++) if (rdbyte(b + 32'(k)) !== frm[k]) bad++;
    check({req, " R3 bytes"}, 32'(bad), 32'd0);
    check({req, " R7 cur"}, cur_desc, daddr((i + 1) % NDESC));
    check({req, " R8 good"}, 32'(n_good - g0), 32'd1);
    check({req, " R8 early/intr"}, 32'((n_early - e0) + (n_intr - q0)), 32'd2);
  endtask

  initial begin
    int idx, n, g0, e0, q0, w0, a0, u0;
    logic ie;
    void'($urandom(32'h5EED1));
    rst_n = 1'b0; rx_enable = 1'b0; long_accept = 1'b0; ucast_accept = 1'b0;
    intr_enable = 1'b0; list_load = 1'b0; list_addr = '0;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    for (int k = 0; k < MEM_WORDS; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 ready", 32'(s_ready), 0);
    check("R1 req", 32'(mem_req), 0);
    check("R1 events", 32'({ev_good, ev_early, ev_intr, ev_unavail}), 0);
    check("R1 cur", cur_desc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cur after release", cur_desc, 0);

    for (int k = 0; k < NDESC; k++) arm(k, 2'b10);
    list_addr = DBASE; list_load = 1'b1; @(negedge clk); list_load = 1'b0;
    check("R7 load", cur_desc, DBASE);
    rx_enable = 1'b1; ucast_accept = 1'b1;

    // directed: 64-byte payload plus 4 CRC bytes reports 68 (R4, R5, R10)
    g0 = n_good; e0 = n_early; q0 = n_intr;
    gen(68); send(68);
    verify("R4 R5 R10 len68", 0, 68, 1'b0, g0, e0, q0);
    idx = 1;

    // random frames, ring wraps around (R3, R5, R7, R8)
    for (int f = 0; f < 7; f++) begin
      arm(idx, 2'b10);
      n  = 16 + int'($urandom % 300);
      ie = 1'($urandom);
      intr_enable = ie;
      g0 = n_good; e0 = n_early; q0 = n_intr;
      gen(n); send(n);
      verify("R3 R5 random", idx, n, ie, g0, e0, q0);
      idx = (idx + 1) % NDESC;
    end

    // CPU-owned descriptor (R2)
    arm(idx, 2'b00);
    w0 = n_wr; u0 = n_unav; g0 = n_good;
    gen(40); send(40);
    check("R2 unavail event", 32'(n_unav - u0), 1);
    check("R2 no write", 32'(n_wr - w0), 0);
    check("R2 cur held", cur_desc, daddr(idx));
    check("R2 no good", 32'(n_good - g0), 0);

    // filter off, then reception off (R9)
    arm(idx, 2'b10);
    ucast_accept = 1'b0;
    a0 = n_acc; g0 = n_good; u0 = n_unav;
    gen(30); send(30);
    check("R9 ucast off no access", 32'(n_acc - a0), 0);
    check("R9 ucast off no event", 32'((n_good - g0) + (n_unav - u0)), 0);
    ucast_accept = 1'b1; rx_enable = 1'b0;
    gen(30); send(30);
    check("R9 rx off no access", 32'(n_acc - a0), 0);
    check("R9 status kept", mem[daddr(idx) >> 2], 32'h8000_0000);
    rx_enable = 1'b1;

    // over-long frame without long accept (R6)
    intr_enable = 1'b1;
    w0 = n_wr; g0 = n_good;
    gen(1600); send(1600);
    check("R6 truncated writes", 32'(n_wr - w0), 32'd1518);
    check("R6 no writeback", mem[daddr(idx) >> 2], 32'h8000_0000);
    check("R6 no advance", cur_desc, daddr(idx));
    check("R6 no event", 32'(n_good - g0), 0);

    // same length with long accept (R6)
    long_accept = 1'b1;
    g0 = n_good; e0 = n_early; q0 = n_intr;
    gen(1600); send(1600);
    verify("R6 long stored", idx, 1600, 1'b1, g0, e0, q0);
    idx = (idx + 1) % NDESC;

    // boundary: exactly 1518 bytes, no long flag (R6)
    long_accept = 1'b0; arm(idx, 2'b10);
    g0 = n_good; e0 = n_early; q0 = n_intr;
    gen(1518); send(1518);
    verify("R6 at max", idx, 1518, 1'b1, g0, e0, q0);

    // reload pointer (R7)
    list_addr = daddr(2); list_load = 1'b1; @(negedge clk); list_load = 1'b0;
    check("R7 reload", cur_desc, daddr(2));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule